// File: doc/BRIEF.md
# Relative Branch Target Unit

This block works out the next program counter for a two-byte conditional relative branch. The first byte of the branch is the opcode and the second is a signed displacement. Each cycle the unit receives the address of the branch, a two-bit condition selector, the displacement byte, the current N, Z and V flags and a strobe that marks a valid branch. It computes the address of the following instruction and the branch target in parallel. It tests the selected condition against the flags and registers the chosen address together with a taken flag.

Both addresses are measured from the same base, which is the branch address plus the instruction length. The displacement is sign-extended to the address width before it is added, and all address arithmetic wraps at the address width. When the strobe is low, the unit registers the incoming program counter unchanged and reports not-taken. This lets an upstream sequencer keep one path for everything that is not a branch.

Top module: `relbr_unit`

## Requirements
- R1: While rst_n is low, next_pc is 0 and br_taken is 0.
- R2: The outputs are registered. A value presented on the inputs before a rising clock edge shows on next_pc and br_taken after that edge, one cycle later.
- R3: When br_valid is 1 and the selected condition fails, next_pc becomes pc_in + 2 and br_taken becomes 0.
- R4: When br_valid is 1 and the condition holds, next_pc becomes pc_in + 2 + the displacement read as a signed byte, and br_taken becomes 1. Bit 7 of disp is copied into the upper byte, so branch 0x0010 with disp 0x11 gives 0x0023, and branch 0x0020 with disp 0xE3 gives 0x0005.
- R5: cond_code 2'b00 (equal) is taken when Z is 1. flags bit 2 is N, bit 1 is Z and bit 0 is V.
- R6: cond_code 2'b01 (not equal) is taken when Z is 0.
- R7: cond_code 2'b10 (less than) is taken when N XOR V is 1.
- R8: cond_code 2'b11 (greater than) is taken when Z is 0 and N XOR V is 0.
- R9: Both the fall-through and the target address wrap modulo 2^16. For example, 0xFFFF falls through to 0x0001.
- R10: When br_valid is 0, next_pc becomes pc_in and br_taken becomes 0, whatever the values of cond_code, disp and flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | A conditional relative branch is present this cycle |
| pc_in | input | 16 | Address of the branch opcode byte |
| cond_code | input | 2 | 00 equal, 01 not equal, 10 less than, 11 greater than |
| disp | input | 8 | Signed displacement byte |
| flags | input | 3 | {N, Z, V} condition flags |
| next_pc | output | 16 | Registered next program counter |
| br_taken | output | 1 | Registered branch-taken indication |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, an 8-bit displacement and a 2-byte instruction. These values bring wrap-around at the top of the address space and displacements with bit 7 set within reach of the directed cases. A sweep drives every condition code against all eight flag patterns, with displacements of both signs. Cycles with the strobe low carry deliberately hostile condition, displacement and flag values, so that any leak of those inputs shows on next_pc or br_taken.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

  typedef enum logic [1:0] {
    CC_EQ = 2'b00,
    CC_NE = 2'b01,
    CC_LT = 2'b10,
    CC_GT = 2'b11
  } cc_e;

  localparam int FLAG_N = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 0;
  localparam int FLAG_W = 3;

  function automatic logic cond_holds(input cc_e code, input logic n, input logic z,
                                      input logic v);
    logic lt;
    lt = n ^ v;
    unique case (code)
      CC_EQ:   return z;
      CC_NE:   return ~z;
      CC_LT:   return lt;
      default: return ~z & ~lt;
    endcase
  endfunction

endpackage

// File: rtl/relbr_cond.sv
module relbr_cond
  import relbr_pkg::*;
(
  input  logic [1:0]        code_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              pass_o
);

  cc_e code;

  always_comb begin
    code   = cc_e'(code_i);
    pass_o = cond_holds(code, flags_i[FLAG_N], flags_i[FLAG_Z], flags_i[FLAG_V]);
  end

endmodule

// File: rtl/relbr_addr.sv
module relbr_addr #(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 8,
  parameter int INSN_BYTES = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] fall_o,
  output logic [ADDR_W-1:0] target_o
);

  localparam int EXT_W = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_extend
      always_comb disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      always_comb disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    fall_o   = wrap_add(pc_i, STEP);
    target_o = wrap_add(fall_o, disp_ext);
  end

endmodule

// File: rtl/relbr_select.sv
module relbr_select #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              pass_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] fall_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_q,
  output logic              taken_q
);

  logic [ADDR_W-1:0] pc_d;
  logic              taken_d;

  always_comb begin
    if (!valid_i) begin
      pc_d    = pc_i;
      taken_d = 1'b0;
    end else if (pass_i) begin
      pc_d    = target_i;
      taken_d = 1'b1;
    end else begin
      pc_d    = fall_i;
      taken_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      taken_q <= taken_d;
    end
  end

endmodule

// File: rtl/relbr_unit.sv
module relbr_unit #(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 8,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [1:0]        cond_code,
  input  logic [DISP_W-1:0] disp,
  input  logic [2:0]        flags,
  output logic [ADDR_W-1:0] next_pc,
  output logic              br_taken
);

  logic              cond_pass;
  logic [ADDR_W-1:0] fall_addr;
  logic [ADDR_W-1:0] target_addr;

  relbr_cond u_cond (
    .code_i  (cond_code),
    .flags_i (flags),
    .pass_o  (cond_pass)
  );

  relbr_addr #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_addr (
    .pc_i     (pc_in),
    .disp_i   (disp),
    .fall_o   (fall_addr),
    .target_o (target_addr)
  );

  relbr_select #(
    .ADDR_W (ADDR_W)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (br_valid),
    .pass_i   (cond_pass),
    .pc_i     (pc_in),
    .fall_i   (fall_addr),
    .target_i (target_addr),
    .pc_q     (next_pc),
    .taken_q  (br_taken)
  );

endmodule

// File: rtl/relbr_unit_chk.sv
module relbr_unit_chk #(
  parameter int ADDR_W     = 16,
  parameter int INSN_BYTES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic [ADDR_W-1:0] pc_in,
  input logic [1:0]        cond_code,
  input logic [2:0]        flags,
  input logic              cond_pass,
  input logic [ADDR_W-1:0] fall_addr,
  input logic [ADDR_W-1:0] target_addr,
  input logic [ADDR_W-1:0] next_pc,
  input logic              br_taken
);

  logic n_f, z_f, v_f;
  assign n_f = flags[2];
  assign z_f = flags[1];
  assign v_f = flags[0];

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (next_pc == '0 && br_taken == 1'b0);
    end
  end

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> (next_pc == $past(pc_in) && !br_taken));

  assert_fall_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> (ADDR_W'(fall_addr - pc_in) == ADDR_W'(INSN_BYTES)));

  assert_fall_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !cond_pass) |=> (next_pc == $past(fall_addr) && !br_taken));

  assert_target_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cond_pass) |=> (next_pc == $past(target_addr) && br_taken));

  assert_eq_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cond_code == 2'b00) |=> (br_taken == $past(z_f)));

  assert_ne_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cond_code == 2'b01) |=> (br_taken == !$past(z_f)));

  assert_lt_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cond_code == 2'b10) |=> (br_taken == ($past(n_f) != $past(v_f))));

  assert_gt_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cond_code == 2'b11) |=>
      (br_taken == (!$past(z_f) && ($past(n_f) == $past(v_f)))));

  assert_taken_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> $past(br_valid));

endmodule

bind relbr_unit relbr_unit_chk #(
  .ADDR_W     (ADDR_W),
  .INSN_BYTES (INSN_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .br_valid    (br_valid),
  .pc_in       (pc_in),
  .cond_code   (cond_code),
  .flags       (flags),
  .cond_pass   (cond_pass),
  .fall_addr   (fall_addr),
  .target_addr (target_addr),
  .next_pc     (next_pc),
  .br_taken    (br_taken)
);

// File: tb/relbr_unit_test.sv
`timescale 1ns/1ps
module relbr_unit_test;

  typedef struct {
    logic [15:0] pc;
    logic        tk;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [15:0] pc_in = '0;
  logic [1:0]  cond_code = '0;
  logic [7:0]  disp = '0;
  logic [2:0]  flags = '0;
  logic [15:0] next_pc;
  logic        br_taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  relbr_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_valid  (br_valid),
    .pc_in     (pc_in),
    .cond_code (cond_code),
    .disp      (disp),
    .flags     (flags),
    .next_pc   (next_pc),
    .br_taken  (br_taken)
  );

  function automatic bit model_taken(input logic [1:0] cc, input logic [2:0] f);
    bit n, z, v;
    n = f[2]; z = f[1]; v = f[0];
    case (cc)
      2'd0: return z;
      2'd1: return !z;
      2'd2: return n != v;
      default: return (z == 1'b0) && (n == v);
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] apc, input logic atk,
                       input logic [15:0] epc, input logic etk);
    checks++;
    if (apc !== epc || atk !== etk) begin
      fails++;
      $display("FAIL %s: actual pc=%h taken=%b expected pc=%h taken=%b",
               tag, apc, atk, epc, etk);
    end
  endtask

  task automatic drive(input bit v, input logic [15:0] pc, input logic [1:0] cc,
                       input logic [7:0] d, input logic [2:0] f, input string tag);
    exp_t e;
    bit t;
    int sum;
    @(negedge clk);
    br_valid = v; pc_in = pc; cond_code = cc; disp = d; flags = f;
    if (!v) begin
      e.pc = pc; e.tk = 1'b0;
    end else begin
      t = model_taken(cc, f);
      sum = int'(pc) + 2 + (t ? int'($signed(d)) : 0);
      e.pc = 16'(sum);
      e.tk = t;
    end
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb.size() > 0) begin
        e = sb.pop_front();
        check(e.tag, next_pc, br_taken, e.pc, e.tk);
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (R2): actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    br_valid = 1'b1; pc_in = 16'h5555; cond_code = 2'd0; flags = 3'b010; disp = 8'h11;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", next_pc, br_taken, 16'h0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    br_valid = 1'b0;

    drive(1, 16'h0010, 2'd0, 8'h11, 3'b010, "R4 forward R5 eq");
    drive(1, 16'h0020, 2'd0, 8'hE3, 3'b010, "R4 backward sign ext");
    drive(1, 16'h0010, 2'd0, 8'h11, 3'b000, "R3 eq fails R5");
    drive(1, 16'h0100, 2'd1, 8'h7F, 3'b000, "R6 ne taken");
    drive(1, 16'h0100, 2'd1, 8'h7F, 3'b010, "R6 ne not taken");
    drive(1, 16'h0200, 2'd2, 8'hF0, 3'b100, "R7 lt N=1 V=0");
    drive(1, 16'h0200, 2'd2, 8'hF0, 3'b101, "R7 lt N=1 V=1");
    drive(1, 16'h0300, 2'd3, 8'h08, 3'b000, "R8 gt taken");
    drive(1, 16'h0300, 2'd3, 8'h08, 3'b010, "R8 gt Z=1");
    drive(1, 16'hFFFE, 2'd0, 8'h05, 3'b010, "R9 wrap target");
    drive(1, 16'hFFFF, 2'd1, 8'h05, 3'b010, "R9 wrap fall");
    drive(1, 16'h0001, 2'd0, 8'h80, 3'b010, "R9 R4 wrap below zero");
    drive(0, 16'h1234, 2'd0, 8'h40, 3'b010, "R10 idle eq ignored");
    drive(0, 16'hABCD, 2'd3, 8'h9C, 3'b000, "R10 idle gt ignored");
    drive(1, 16'h0400, 2'd3, 8'h02, 3'b011, "R2 back-to-back");

    for (int cc = 0; cc < 4; cc++) begin
      for (int f = 0; f < 8; f++) begin
        drive(1, 16'(16'h4000 + cc * 64 + f * 4), 2'(cc), 8'(f * 37 + cc * 11),
              3'(f), "R5 R6 R7 R8 sweep");
      end
    end

    drive(0, 16'h0BAD, 2'd2, 8'hFF, 3'b100, "R10 final idle");
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: actual pending=%0d expected pending=0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule